// File: doc/BRIEF.md
# SPI Register-File Slave Port

This block is the serial front end of a UART's control space. An external host reaches 32 byte-wide registers over a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge). Every access is a 16-bit frame. The first byte carries a direction flag and a register address. The second byte carries the write data from the host, or the read data returned to the host. The SPI pins are asynchronous to the block's system clock. They are brought into the clock domain through synchronizer chains, and every action happens on the system clock.

Address 0 is not a storage location. It is a window onto the UART's character queues: writing it pushes a byte toward the transmitter, and reading it pops a byte from the receiver. Four interrupt-status registers clear their sticky bits when read. The block raises a clear strobe for them once a read completes. Seven registers are read-only, and writes to them are dropped. The top register returns a fixed revision code from a parameter.

The register storage and the FIFOs sit outside this block. They connect through the address, read-data, write-data and strobe ports.

Top module: `spi_regfile_slave`

## Requirements
- R1: In the address byte, bit 7 set to 1 selects a write and 0 selects a read. Bits 4:0 give the register address, and bits 6:5 are ignored.
- R2: A completed write to address 0x00 gives exactly one `tx_push` pulse carrying the data byte on `wr_data`, and no `reg_wr`. It is issued after the 16th SCLK rising edge, before CS_n rises.
- R3: A completed write to any writable address from 0x01 to 0x1E gives one `reg_wr` pulse, with that address on `reg_addr` and the data byte on `wr_data`.
- R4: Writes to the read-only addresses 0x02, 0x04, 0x06, 0x08, 0x11, 0x12 and 0x1F give no strobe at all.
- R5: In a read, MISO carries the selected register MSB first. Bit 7 is valid after the SCLK falling edge that follows the 8th rising edge, and the next bits follow on the next falling edges. MISO is low while CS_n is high.
- R6: A read of address 0x00 returns `rx_data` and gives one `rx_pop` pulse. The pulse comes only after CS_n rises following a complete 16-bit frame.
- R7: A completed read of 0x02, 0x04, 0x06 or 0x08 gives one `stat_clr` pulse with that address on `reg_addr`, after CS_n rises. A read of any other address gives no `stat_clr`, and the byte returned is `reg_rd_data`.
- R8: A read of 0x1F returns the parameter REV_ID (default 0xA1, whose value ANDed with 0xFE is 0xA0), whatever `reg_rd_data` holds.
- R9: If CS_n rises before the 16th SCLK rising edge, in the address byte or in the data byte, the access is dropped and no strobe is issued.
- R10: Every strobe lasts exactly one clock cycle, and at most one of `tx_push`, `rx_pop`, `reg_wr`, `stat_clr` is high in any cycle.
- R11: While `rst` is high and after it is released, MISO and all strobes are low.
- R12: SCLK pulses after the 16th in the same CS_n frame are ignored, so a write is issued only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idles low (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 5 | Register address of the current access |
| reg_rd_data | input | 8 | Register-file contents at `reg_addr` |
| reg_wr | output | 1 | One-cycle write strobe to the register file |
| stat_clr | output | 1 | One-cycle clear strobe for a status register at `reg_addr` |
| wr_data | output | 8 | Data byte for `reg_wr` or `tx_push` |
| tx_push | output | 1 | One-cycle push into the transmit FIFO |
| rx_data | input | 8 | Head of the receive FIFO |
| rx_pop | output | 1 | One-cycle pop from the receive FIFO |

## Verification
The bench aims at the side effects and when they happen. A design that pops or clears at the 16th edge, instead of at CS_n rising, shows the strobe before the deselect. A design that skips the completeness check pops the FIFO on a frame cut off in the data byte. Writes to each read-only address, a header with bits 6:5 set, extra SCLK pulses after the frame, and reads of the revision register with junk on `reg_rd_data` each expose a wrong decode, a second write, or a byte taken from the wrong source.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  localparam int ADDR_W = 5;

  typedef logic [ADDR_W-1:0] rf_addr_t;

  localparam rf_addr_t FIFO_ADDR = '0;
  localparam rf_addr_t REV_ADDR  = '1;

  // Registers whose sticky bits clear on a completed read.
  function automatic logic is_status(rf_addr_t a);
    return (a == 5'h02) || (a == 5'h04) || (a == 5'h06) || (a == 5'h08);
  endfunction

  // Registers the host may not write.
  function automatic logic is_read_only(rf_addr_t a);
    return is_status(a) || (a == 5'h11) || (a == 5'h12) || (a == REV_ADDR);
  endfunction

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level
);

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], async_in[g]};
      end
      assign level[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
  import spi_rf_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] rd_byte,
  output logic              hdr_done,
  output logic              hdr_wr,
  output rf_addr_t          hdr_addr,
  output logic              data_done,
  output logic [WORD_W-1:0] data_byte,
  output logic              complete,
  output logic              cs_rise,
  output logic              miso
);

  localparam int FRAME = 2 * WORD_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int IDX_W = $clog2(WORD_W);

  logic              sclk_q, csn_q, ld_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh_in, rd_sh, nxt_bits;
  logic [CNT_W-1:0]  rem;
  logic              sclk_rise, sclk_fall, in_data, data_bit;

  assign sclk_rise = sclk_s & ~sclk_q & ~csn_s;
  assign sclk_fall = ~sclk_s & sclk_q & ~csn_s;
  assign cs_rise   = csn_s & ~csn_q;
  assign complete  = (cnt == CNT_W'(FRAME));
  assign nxt_bits  = {sh_in[WORD_W-2:0], mosi_s};
  assign in_data   = (cnt >= CNT_W'(WORD_W)) && (cnt < CNT_W'(FRAME));
  assign rem       = CNT_W'(FRAME - 1) - cnt;
  assign data_bit  = rd_sh[rem[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      csn_q     <= 1'b1;
      cnt       <= '0;
      sh_in     <= '0;
      rd_sh     <= '0;
      ld_q      <= 1'b0;
      hdr_done  <= 1'b0;
      hdr_wr    <= 1'b0;
      hdr_addr  <= '0;
      data_done <= 1'b0;
      data_byte <= '0;
      miso      <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      csn_q     <= csn_s;
      hdr_done  <= 1'b0;
      data_done <= 1'b0;
      ld_q      <= hdr_done;
      if (ld_q) rd_sh <= rd_byte;
      if (csn_s) begin
        cnt  <= '0;
        miso <= 1'b0;
      end else begin
        if (sclk_rise && !complete) begin
          cnt   <= cnt + 1'b1;
          sh_in <= nxt_bits;
          if (cnt == CNT_W'(WORD_W - 1)) begin
            hdr_done <= 1'b1;
            hdr_wr   <= nxt_bits[WORD_W-1];
            hdr_addr <= nxt_bits[ADDR_W-1:0];
          end
          if (cnt == CNT_W'(FRAME - 1)) begin
            data_done <= 1'b1;
            data_byte <= nxt_bits;
          end
        end
        if (sclk_fall) miso <= in_data ? data_bit : 1'b0;
      end
    end
  end

  AST_DATA_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
    data_done |-> !hdr_done && complete) // R12
    else $error("data byte finished without a full frame");

endmodule

// File: rtl/spi_rf_decode.sv
module spi_rf_decode
  import spi_rf_pkg::*;
#(
  parameter int              WORD_W = 8,
  parameter logic [WORD_W-1:0] REV_ID = 8'hA1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_wr,
  input  rf_addr_t          hdr_addr,
  input  logic              data_done,
  input  logic [WORD_W-1:0] data_byte,
  input  logic              cs_rise,
  input  logic              complete,
  input  logic [WORD_W-1:0] rx_data,
  input  logic [WORD_W-1:0] reg_rd_data,
  output logic [WORD_W-1:0] rd_byte,
  output logic              tx_push,
  output logic              rx_pop,
  output logic              reg_wr,
  output logic              stat_clr,
  output logic [WORD_W-1:0] wr_data
);

  always_comb begin
    if (hdr_addr == FIFO_ADDR)     rd_byte = rx_data;
    else if (hdr_addr == REV_ADDR) rd_byte = REV_ID;
    else                           rd_byte = reg_rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
      reg_wr   <= 1'b0;
      stat_clr <= 1'b0;
      wr_data  <= '0;
    end else begin
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
      reg_wr   <= 1'b0;
      stat_clr <= 1'b0;
      if (data_done && hdr_wr) begin
        wr_data <= data_byte;
        if (hdr_addr == FIFO_ADDR)         tx_push <= 1'b1;
        else if (!is_read_only(hdr_addr))  reg_wr  <= 1'b1;
      end
      if (cs_rise && complete && !hdr_wr) begin
        if (hdr_addr == FIFO_ADDR)         rx_pop   <= 1'b1;
        else if (is_status(hdr_addr))      stat_clr <= 1'b1;
      end
    end
  end

  AST_WR_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || tx_push) |-> $past(data_done)) // R2
    else $error("write strobe without finished data byte");

  AST_READ_EFFECT_AT_CS: assert property (@(posedge clk) disable iff (rst)
    (rx_pop || stat_clr) |-> $past(cs_rise)) // R6
    else $error("read side effect not tied to deselect");

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_push, rx_pop, reg_wr, stat_clr})) // R10
    else $error("several strobes at once");

  AST_POP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop) // R10
    else $error("pop longer than one cycle");

  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_push) // R10
    else $error("push longer than one cycle");

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int                WORD_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] REV_ID      = 8'hA1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_rd_data,
  output logic              reg_wr,
  output logic              stat_clr,
  output logic [WORD_W-1:0] wr_data,
  output logic              tx_push,
  input  logic [WORD_W-1:0] rx_data,
  output logic              rx_pop
);

  logic [2:0]        pins_s;
  logic              hdr_done, hdr_wr, data_done, complete, cs_rise;
  rf_addr_t          hdr_addr;
  logic [WORD_W-1:0] data_byte, rd_byte;

  // Order {mosi, cs_n, sclk}; cs_n resets high.
  spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({spi_mosi, spi_cs_n, spi_sclk}),
    .level    (pins_s)
  );

  spi_rf_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s[0]),
    .csn_s     (pins_s[1]),
    .mosi_s    (pins_s[2]),
    .rd_byte   (rd_byte),
    .hdr_done  (hdr_done),
    .hdr_wr    (hdr_wr),
    .hdr_addr  (hdr_addr),
    .data_done (data_done),
    .data_byte (data_byte),
    .complete  (complete),
    .cs_rise   (cs_rise),
    .miso      (spi_miso)
  );

  spi_rf_decode #(.WORD_W(WORD_W), .REV_ID(REV_ID)) u_dec (
    .clk         (clk),
    .rst         (rst),
    .hdr_wr      (hdr_wr),
    .hdr_addr    (hdr_addr),
    .data_done   (data_done),
    .data_byte   (data_byte),
    .cs_rise     (cs_rise),
    .complete    (complete),
    .rx_data     (rx_data),
    .reg_rd_data (reg_rd_data),
    .rd_byte     (rd_byte),
    .tx_push     (tx_push),
    .rx_pop      (rx_pop),
    .reg_wr      (reg_wr),
    .stat_clr    (stat_clr),
    .wr_data     (wr_data)
  );

  assign reg_addr = hdr_addr;

  AST_NO_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !is_read_only(reg_addr) && (reg_addr != FIFO_ADDR)) // R4
    else $error("write strobe on a protected address");

  AST_CLR_ONLY_STATUS: assert property (@(posedge clk) disable iff (rst)
    stat_clr |-> is_status(reg_addr)) // R7
    else $error("clear strobe on a non-status address");

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(pins_s[1]) && pins_s[1]) |=> !spi_miso) // R5
    else $error("MISO active while deselected");

endmodule

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;

  localparam int H = 8; // clk cycles per SCLK half period

  typedef struct packed {
    logic [7:0] hdr;
    logic [7:0] dat;
    logic [4:0] nb;
    logic [7:0] rxv;
    logic [7:0] regv;
    logic       chk_rd;
    logic [7:0] exp_rd;
    logic [3:0] exp_sb;   // {push, pop, wr, clr}
    logic [4:0] exp_addr;
    logic [7:0] exp_wd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'h80, 8'h5A, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b1000, 5'h00, 8'h5A},
    '{8'h81, 8'h3C, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0010, 5'h01, 8'h3C},
    '{8'h82, 8'hFF, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h91, 8'h77, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h9F, 8'h12, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h89, 8'hC3, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0010, 5'h09, 8'hC3},
    '{8'h00, 8'h00, 5'd16, 8'hA5, 8'h00, 1'b1, 8'hA5, 4'b0100, 5'h00, 8'h00},
    '{8'h04, 8'h00, 5'd16, 8'h00, 8'h96, 1'b1, 8'h96, 4'b0001, 5'h04, 8'h00},
    '{8'h0B, 8'h00, 5'd16, 8'h00, 8'h3E, 1'b1, 8'h3E, 4'b0000, 5'h00, 8'h00},
    '{8'h1F, 8'h00, 5'd16, 8'h00, 8'h55, 1'b1, 8'hA1, 4'b0000, 5'h00, 8'h00},
    '{8'h08, 8'h00, 5'd16, 8'h00, 8'h01, 1'b1, 8'h01, 4'b0001, 5'h08, 8'h00},
    '{8'hE3, 8'h44, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0010, 5'h03, 8'h44},
    '{8'h60, 8'h00, 5'd16, 8'h0F, 8'h00, 1'b1, 8'h0F, 4'b0100, 5'h00, 8'h00},
    '{8'h81, 8'h99, 5'd12, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h00, 8'h00, 5'd12, 8'h33, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h81, 8'h55, 5'd5,  8'h00, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h12, 8'h00, 5'd16, 8'h00, 8'h40, 1'b1, 8'h40, 4'b0000, 5'h00, 8'h00},
    '{8'h86, 8'hAB, 5'd16, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0000, 5'h00, 8'h00},
    '{8'h81, 8'h11, 5'd20, 8'h00, 8'h00, 1'b0, 8'h00, 4'b0010, 5'h01, 8'h11},
    '{8'h02, 8'h00, 5'd16, 8'h00, 8'h80, 1'b1, 8'h80, 4'b0001, 5'h02, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, reg_wr, stat_clr, tx_push, rx_pop;
  logic [4:0] reg_addr;
  logic [7:0] wr_data, reg_rd_data = 8'h00, rx_data = 8'h00;

  int checks = 0, failures = 0;
  int n_push = 0, n_pop = 0, n_wr = 0, n_clr = 0, n_long = 0, n_multi = 0;
  logic [4:0] last_addr = '0;
  logic [7:0] last_wd = '0;
  logic [3:0] prev_sb = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_regfile_slave u_spi_regfile_slave (
    .clk (clk), .rst (rst), .spi_sclk (sclk), .spi_cs_n (cs_n),
    .spi_mosi (mosi), .spi_miso (miso), .reg_addr (reg_addr),
    .reg_rd_data (reg_rd_data), .reg_wr (reg_wr), .stat_clr (stat_clr),
    .wr_data (wr_data), .tx_push (tx_push), .rx_data (rx_data), .rx_pop (rx_pop)
  );

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    logic [3:0] sb;
    sb = {tx_push, rx_pop, reg_wr, stat_clr};
    if (!rst) begin
      if (tx_push)  n_push++;
      if (rx_pop)   n_pop++;
      if (reg_wr)   n_wr++;
      if (stat_clr) n_clr++;
      if (|sb) begin last_addr = reg_addr; last_wd = wr_data; end
      if (|(sb & prev_sb)) n_long++;
      if ($countones(sb) > 1) n_multi++;
    end
    prev_sb = sb;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int total();
    return n_push + n_pop + n_wr + n_clr;
  endfunction

  task automatic xfer(input logic [7:0] hdr, input logic [7:0] dat, input int nb,
                      output logic [7:0] rd, output int pre);
    logic [15:0] word;
    word = {hdr, dat};
    rd = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 16) ? word[15-i] : 1'b0;
      repeat (H) @(negedge clk);
      if (i >= 8 && i < 16) rd[15-i] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2*H) @(negedge clk);
    pre = total();
    cs_n = 1'b1; mosi = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: outputs quiet in reset
    check(miso == 1'b0, "R11 miso in reset", miso, 0);
    check({tx_push, rx_pop, reg_wr, stat_clr} == 4'b0, "R11 strobes in reset",
          {tx_push, rx_pop, reg_wr, stat_clr}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(total() == 0 && miso == 1'b0, "R11 quiet after reset", total(), 0);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int b_push, b_pop, b_wr, b_clr, b_tot, pre;
      logic [7:0] rd;
      logic [3:0] got;
      t = VECS[v];
      rx_data = t.rxv; reg_rd_data = t.regv;
      b_push = n_push; b_pop = n_pop; b_wr = n_wr; b_clr = n_clr; b_tot = total();
      xfer(t.hdr, t.dat, int'(t.nb), rd, pre);
      got = {n_push != b_push, n_pop != b_pop, n_wr != b_wr, n_clr != b_clr};
      check(got == t.exp_sb && total() - b_tot == int'($countones(t.exp_sb)),
            $sformatf("R1 R2 R3 R4 R6 R7 R9 R12 strobe set vec %0d", v),
            got, t.exp_sb);
      if (t.chk_rd)
        check(rd == t.exp_rd, $sformatf("R5 R8 read byte vec %0d", v), rd, t.exp_rd);
      if (|t.exp_sb)
        check(last_addr == t.exp_addr, $sformatf("R1 strobe address vec %0d", v),
              last_addr, t.exp_addr);
      if (t.exp_sb[3] || t.exp_sb[1])
        check(last_wd == t.exp_wd, $sformatf("R2 R3 write data vec %0d", v),
              last_wd, t.exp_wd);
      // Writes act before deselect; reads act only after it (R6, R7).
      check(pre - b_tot == ((t.exp_sb[3] || t.exp_sb[1]) ? 1 : 0),
            $sformatf("R6 effect timing vec %0d", v), pre - b_tot,
            (t.exp_sb[3] || t.exp_sb[1]) ? 1 : 0);
      check(miso == 1'b0, $sformatf("R5 miso idle vec %0d", v), miso, 0);
    end

    // R10: every strobe single-cycle and never two at once
    check(n_long == 0, "R10 strobe wider than one cycle", n_long, 0);
    check(n_multi == 0, "R10 simultaneous strobes", n_multi, 0);

    // R11: reset in mid-frame clears everything, next read still works
    @(negedge clk); cs_n = 1'b0;
    repeat (3*H) @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(miso == 1'b0 && {tx_push, rx_pop, reg_wr, stat_clr} == 4'b0,
          "R11 mid-frame reset", miso, 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    begin
      logic [7:0] rd;
      int pre, b;
      b = n_pop;
      rx_data = 8'hC7;
      xfer(8'h00, 8'h00, 16, rd, pre);
      check(rd == 8'hC7 && n_pop == b + 1, "R6 read after reset", rd, 8'hC7);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule